// File: doc/BRIEF.md
# LIN Break Field Detector

This block watches an asynchronous serial receive line and recognises the long dominant (low) period that opens a LIN frame. It synchronises the line, finds a falling edge, and then samples the line once per bit time near the middle of each bit. The timing comes from an oversampling tick input. Each low sample adds one to a saturating counter. When the line is sampled high again, the count is compared with a minimum break length. A long enough low period raises a one-cycle valid-break pulse and a receive interrupt pulse, and sets a completion flag. A short one is dropped without any report, and the block waits for the next break.

While break mode is in force, the shared receiver does not run as a normal UART. The receive shift register stays at all ones, the receive data register is not written, and no parity, framing or overrun event can be raised. After a valid break the block returns to normal byte reception by itself and holds the completion flag until software clears it. The valid-break pulse is meant to start an external timer that measures the sync field. In normal mode the same path receives 8-bit characters, least significant bit first, with an optional even-parity bit. Every falling edge seen while the receiver is idle produces a wake-up pulse.

Top module: `lin_break_detector`

## Requirements
- R1: After reset, wake_o, brk_valid_o, irq_o, brk_done_o, rx_valid_o, perr_o, ferr_o and ovr_o are 0 and rx_data_o is 0.
- R2: In break mode, a low period of MIN_BITS (default 11) or more bit times followed by a high sample gives exactly one single-cycle brk_valid_o pulse, with irq_o high in the same cycle.
- R3: In break mode, a low period shorter than MIN_BITS bit times gives no brk_valid_o, no irq_o and no brk_done_o, and the block stays in break mode so that a following long break is still accepted.
- R4: The low-bit counter saturates at 2^CNT_W-1 (255 by default). A low period far longer than that, followed by high, is still reported as a valid break.
- R5: brk_done_o rises together with brk_valid_o and stays high until a brk_clr_i pulse. While it is high the receiver works in normal mode even when brk_mode_i is 1.
- R6: During a break-mode reception, rx_valid_o, perr_o, ferr_o and ovr_o stay 0, rx_data_o keeps its value, and the internal shift register holds all ones.
- R7: wake_o gives one single-cycle pulse for each falling edge of the synchronised line that arrives while the receiver is idle.
- R8: In normal mode (brk_mode_i = 0, or brk_done_o = 1), a frame of one low start bit, DATA_W data bits least significant first, a parity bit when PARITY_EN = 1, and a stop bit loads rx_data_o. The frame gives one rx_valid_o pulse with irq_o in the same cycle.
- R9: In normal mode, perr_o pulses with rx_valid_o when the parity bit differs from the XOR of the data bits (even parity). ferr_o pulses with rx_valid_o when the stop bit is sampled low.
- R10: ovr_o pulses with rx_valid_o when a character completes while the previous one has not been taken by an rx_ack_i pulse. The new character still replaces rx_data_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| tick_i | input | 1 | One-cycle oversampling tick, OVS ticks per bit |
| brk_mode_i | input | 1 | 1 selects break detection, 0 selects normal reception |
| brk_clr_i | input | 1 | Clears the break completion flag |
| rx_ack_i | input | 1 | Marks the received character as taken |
| wake_o | output | 1 | Wake-up pulse on an idle-time falling edge |
| brk_valid_o | output | 1 | Valid break pulse, starts the sync-field timer |
| irq_o | output | 1 | Receive interrupt pulse (valid break or character) |
| brk_done_o | output | 1 | Break seen, held until cleared |
| rx_data_o | output | DATA_W | Receive data register |
| rx_valid_o | output | 1 | Character received pulse |
| perr_o | output | 1 | Parity error pulse |
| ferr_o | output | 1 | Framing error pulse |
| ovr_o | output | 1 | Overrun error pulse |

## Verification
The bench builds the block with OVS = 8, MIN_BITS = 11, CNT_W = 8, DATA_W = 8 and PARITY_EN = 1. It drives a tick every second clock, so one bit lasts 16 cycles. At that length a break of 300 bit times runs the counter well past its 255 ceiling in a few thousand cycles. With the threshold at 11, the bench can test both sides of it exactly: 10, 11 and 13 bits, plus random lengths from 1 to 24. The parity stage is built in, so parity errors, framing errors and overruns are all reachable, both in normal-mode characters and in characters received after a break.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic wake;
        logic brk_valid;
        logic irq;
        logic rx_valid;
        logic perr;
        logic ferr;
        logic ovr;
    } rx_evt_t;

    function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
        return (v >= lim) ? lim : v + 1;
    endfunction

endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign line_o = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/lin_brk_sampler.sv
module lin_brk_sampler #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic run_i,
    input  logic tick_i,
    output logic samp_o
);
    localparam int PH_W = $clog2(OVS);
    localparam logic [PH_W-1:0] HALF_M1 = PH_W'(OVS / 2 - 1);
    localparam logic [PH_W-1:0] FULL_M1 = PH_W'(OVS - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) ph_q <= HALF_M1;
        else if (run_i && tick_i) ph_q <= (ph_q == '0) ? FULL_M1 : ph_q - 1'b1;
    end

    assign samp_o = run_i & tick_i & (ph_q == '0);
endmodule

// File: rtl/lin_brk_lowcnt.sv
module lin_brk_lowcnt
    import lin_brk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int unsigned CMAX = (1 << CNT_W) - 1;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_o <= '0;
        else if (inc_i)   cnt_o <= CNT_W'(sat_inc(32'(cnt_o), CMAX));
    end

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && cnt_o == CNT_W'(CMAX)) |=> (cnt_o == CNT_W'(CMAX)));
endmodule

// File: rtl/lin_break_detector.sv
module lin_break_detector
    import lin_brk_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int MIN_BITS  = 11,
    parameter int CNT_W     = 8,
    parameter int DATA_W    = 8,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd_i,
    input  logic              tick_i,
    input  logic              brk_mode_i,
    input  logic              brk_clr_i,
    input  logic              rx_ack_i,
    output logic              wake_o,
    output logic              brk_valid_o,
    output logic              irq_o,
    output logic              brk_done_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              perr_o,
    output logic              ferr_o,
    output logic              ovr_o
);
    localparam int BI_W = $clog2(DATA_W);
    localparam logic [BI_W-1:0] BIT_LAST = BI_W'(DATA_W - 1);

    rx_state_e         state_q;
    rx_evt_t           evt_q;
    logic              done_q, full_q, par_q, pbad_q;
    logic [DATA_W-1:0] shift_q, data_q;
    logic [BI_W-1:0]   bit_q;
    logic              line, fall, samp, eff_brk, low_long, frame_start;
    logic [CNT_W-1:0]  low_cnt;

    lin_brk_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rxd_i), .line_o(line), .fall_o(fall)
    );

    assign frame_start = (state_q == ST_IDLE) && fall;

    lin_brk_sampler #(.OVS(OVS)) u_samp (
        .clk(clk), .rst(rst), .start_i(frame_start),
        .run_i(state_q != ST_IDLE), .tick_i(tick_i), .samp_o(samp)
    );

    lin_brk_lowcnt #(.CNT_W(CNT_W)) u_low (
        .clk(clk), .rst(rst), .clr_i(frame_start),
        .inc_i((state_q == ST_BRK) && samp && !line), .cnt_o(low_cnt)
    );

    assign eff_brk  = brk_mode_i & ~done_q;
    assign low_long = (low_cnt >= CNT_W'(MIN_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            evt_q   <= '0;
            done_q  <= 1'b0;
            full_q  <= 1'b0;
            par_q   <= 1'b0;
            pbad_q  <= 1'b0;
            shift_q <= '1;
            data_q  <= '0;
            bit_q   <= '0;
        end else begin
            evt_q <= '0;
            if (rx_ack_i)  full_q <= 1'b0;
            if (brk_clr_i) done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (fall) begin
                    evt_q.wake <= 1'b1;
                    shift_q    <= '1;
                    bit_q      <= '0;
                    par_q      <= 1'b0;
                    pbad_q     <= 1'b0;
                    state_q    <= eff_brk ? ST_BRK : ST_START;
                end
                ST_BRK: if (samp && line) begin
                    if (low_long) begin
                        evt_q.brk_valid <= 1'b1;
                        evt_q.irq       <= 1'b1;
                        done_q          <= 1'b1;
                    end
                    state_q <= ST_IDLE;
                end
                ST_START: if (samp) state_q <= line ? ST_IDLE : ST_DATA;
                ST_DATA: if (samp) begin
                    shift_q <= {line, shift_q[DATA_W-1:1]};
                    par_q   <= par_q ^ line;
                    bit_q   <= bit_q + 1'b1;
                    if (bit_q == BIT_LAST) state_q <= PARITY_EN ? ST_PAR : ST_STOP;
                end
                ST_PAR: if (samp) begin
                    pbad_q  <= line ^ par_q;
                    state_q <= ST_STOP;
                end
                ST_STOP: if (samp) begin
                    data_q         <= shift_q;
                    evt_q.rx_valid <= 1'b1;
                    evt_q.irq      <= 1'b1;
                    evt_q.ferr     <= ~line;
                    evt_q.perr     <= pbad_q;
                    evt_q.ovr      <= full_q;
                    full_q         <= 1'b1;
                    state_q        <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wake_o      = evt_q.wake;
    assign brk_valid_o = evt_q.brk_valid;
    assign irq_o       = evt_q.irq;
    assign rx_valid_o  = evt_q.rx_valid;
    assign perr_o      = evt_q.perr;
    assign ferr_o      = evt_q.ferr;
    assign ovr_o       = evt_q.ovr;
    assign brk_done_o  = done_q;
    assign rx_data_o   = data_q;

    // R2
    brk_irq_chk: assert property (@(posedge clk) disable iff (rst)
        brk_valid_o |-> (irq_o && !rx_valid_o));
    // R2
    brk_single_chk: assert property (@(posedge clk) disable iff (rst)
        brk_valid_o |=> !brk_valid_o);
    // R3
    brk_len_chk: assert property (@(posedge clk) disable iff (rst)
        brk_valid_o |-> $past(low_cnt >= CNT_W'(MIN_BITS)));
    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_done_o) |-> brk_valid_o);
    // R6
    brk_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK) |-> (shift_q == '1));
    // R6
    brk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BRK) |=> (!rx_valid_o && !perr_o && !ferr_o && !ovr_o && $stable(rx_data_o)));
    // R7
    wake_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (state_q != ST_IDLE));
endmodule

// File: tb/lin_break_detector_test.sv
module lin_break_detector_test;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 8;
    localparam int MIN_BITS   = 11;
    localparam int BIT_CYC    = 2 * OVS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd_i = 1'b1;
    logic       tick_i = 1'b0;
    logic       brk_mode_i = 1'b1;
    logic       brk_clr_i = 1'b0;
    logic       rx_ack_i = 1'b0;
    logic       wake_o, brk_valid_o, irq_o, brk_done_o, rx_valid_o, perr_o, ferr_o, ovr_o;
    logic [7:0] rx_data_o;

    int n_chk = 0, n_err = 0;
    int c_wake = 0, c_bv = 0, c_irq = 0, c_rxv = 0, c_perr = 0, c_ferr = 0, c_ovr = 0;
    bit finished = 1'b0;
    bit exp_full = 1'b0;

    lin_break_detector #(
        .OVS(OVS), .MIN_BITS(MIN_BITS), .CNT_W(8), .DATA_W(8), .PARITY_EN(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .rxd_i(rxd_i), .tick_i(tick_i), .brk_mode_i(brk_mode_i),
        .brk_clr_i(brk_clr_i), .rx_ack_i(rx_ack_i), .wake_o(wake_o),
        .brk_valid_o(brk_valid_o), .irq_o(irq_o), .brk_done_o(brk_done_o),
        .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .perr_o(perr_o),
        .ferr_o(ferr_o), .ovr_o(ovr_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        tick_i <= rst ? 1'b0 : ~tick_i;
        if (!rst) begin
            c_wake += int'(wake_o);
            c_bv   += int'(brk_valid_o);
            c_irq  += int'(irq_o);
            c_rxv  += int'(rx_valid_o);
            c_perr += int'(perr_o);
            c_ferr += int'(ferr_o);
            c_ovr  += int'(ovr_o);
        end
    end

    function automatic int exp_break(input int n);
        return (n >= MIN_BITS) ? 1 : 0;
    endfunction

    function automatic logic exp_parity(input logic [7:0] d);
        return ^d;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bits(input logic v, input int n);
        rxd_i = v;
        repeat (n * BIT_CYC) @(negedge clk);
    endtask

    task automatic pulse_clr();
        brk_clr_i = 1'b1;
        @(negedge clk);
        brk_clr_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        rx_ack_i = 1'b1;
        @(negedge clk);
        rx_ack_i = 1'b0;
        exp_full = 1'b0;
        @(negedge clk);
    endtask

    // break in break mode: n low bits then high
    task automatic do_break(input int n);
        int w0, b0, i0, r0, e0;
        logic [7:0] d0;
        w0 = c_wake; b0 = c_bv; i0 = c_irq; r0 = c_rxv;
        e0 = c_perr + c_ferr + c_ovr; d0 = rx_data_o;
        bits(1'b0, n);
        bits(1'b1, 3);
        chk((n >= MIN_BITS) ? "R2 valid break pulse" : "R3 short break no pulse", c_bv - b0, exp_break(n));
        chk((n >= MIN_BITS) ? "R2 irq with break" : "R3 no irq on short break", c_irq - i0, exp_break(n));
        chk("R5 done flag", int'(brk_done_o), exp_break(n));
        chk("R7 one wake per edge", c_wake - w0, 1);
        chk("R6 no data or errors in break mode", c_rxv - r0 + c_perr + c_ferr + c_ovr - e0, 0);
        chk("R6 data register unchanged", int'(rx_data_o), int'(d0));
    endtask

    // normal character
    task automatic do_byte(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int r0, i0, p0, f0, o0;
        r0 = c_rxv; i0 = c_irq; p0 = c_perr; f0 = c_ferr; o0 = c_ovr;
        bits(1'b0, 1);
        for (int k = 0; k < 8; k++) bits(d[k], 1);
        bits(exp_parity(d) ^ bad_par, 1);
        bits(~bad_stop, 1);
        bits(1'b1, 2);
        chk("R8 character received", c_rxv - r0, 1);
        chk("R8 irq with character", c_irq - i0, 1);
        chk("R8 data value", int'(rx_data_o), int'(d));
        chk("R9 parity error", c_perr - p0, int'(bad_par));
        chk("R9 framing error", c_ferr - f0, int'(bad_stop));
        chk("R10 overrun", c_ovr - o0, int'(exp_full));
        exp_full = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wake", int'(wake_o), 0);
        chk("R1 brk_valid", int'(brk_valid_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 done", int'(brk_done_o), 0);
        chk("R1 rx_valid", int'(rx_valid_o), 0);
        chk("R1 errors", int'(perr_o) + int'(ferr_o) + int'(ovr_o), 0);
        chk("R1 data", int'(rx_data_o), 0);
        bits(1'b1, 2);

        // R3 boundary below threshold, then still in break mode
        do_break(MIN_BITS - 1);
        do_break(MIN_BITS);
        pulse_clr();
        chk("R5 done cleared", int'(brk_done_o), 0);
        do_break(13);
        // R5 after break: normal reception despite brk_mode_i = 1
        do_byte(8'hA5, 1'b0, 1'b0);
        pulse_ack();
        do_byte(8'h3C, 1'b1, 1'b0);
        pulse_ack();
        do_byte(8'h81, 1'b0, 1'b1);
        // R10 overrun: no ack before the next character
        do_byte(8'h5A, 1'b0, 1'b0);
        pulse_ack();
        pulse_clr();
        // R4 saturation
        do_break(300);
        pulse_clr();
        do_break(1);

        // random mix
        for (int it = 0; it < 24; it++) begin
            if ($urandom % 2 == 0) begin
                brk_mode_i = 1'b1;
                do_break(1 + int'($urandom % 24));
                pulse_clr();
            end else begin
                brk_mode_i = 1'b0;
                do_byte(8'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 5 == 0));
                if ($urandom % 3 != 0) pulse_ack();
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule